// File: doc/BRIEF.md
# Bob Deinterlacer with Field Selection

This block sits on a pixel stream and turns interlaced fields into full-height frames by line doubling. Every line of a field that is kept is sent out once as it arrives and then once more from a single on-chip line store, so the output frame has twice as many lines as the field. A run-time field-selection mode keeps field 0 only, field 1 only, or both parities. A field of a parity that is not kept is swallowed whole. Progressive frames, and all traffic while the block is disabled, go through with no change.

Both stream sides use valid/ready handshaking. A beat moves when valid and ready are both high at a rising clock edge. The output side is one register stage. When the downstream sink holds `m_ready` low, the stage keeps its beat and the input side stalls. The block also holds `s_ready` low while it replays a stored line, and it takes no input during that time. A field that is being dropped is taken at full rate, even when the output is stalled.

The frame type arrives on a sideband input and is read only on the start-of-frame beat. The enable and mode inputs are also read only on that beat. Three counters report how many frames were passed, doubled and dropped. A line wider than the store is still forwarded live in full. Its repeated copy holds only the first words that fit in the store.

Top module: `bob_deint`

## Requirements
- R1: A frame whose `s_ftype` on its start beat is 0 or 3 (progressive) is forwarded beat for beat with data, `m_sof`, `m_eol` and `m_eof` equal to the input, whatever `cfg_mode` is.
- R2: When `cfg_en` is 0 on the start beat, the frame is forwarded unchanged, whatever its field type is.
- R3: For a doubled field (enabled, `s_ftype` 1 = field 0 or 2 = field 1), every line is output live and then at once repeated word for word. `m_sof` is high only on the first live beat. `m_eol` is high on the last beat of each copy. `m_eof` is high only on the last beat of the repeat of the final line.
- R4: With `cfg_mode` = 1 (field 0 only), a field 1 frame gives no output beat. `s_ready` stays high for every beat of that frame.
- R5: With `cfg_mode` = 2 (field 1 only), a field 0 frame gives no output beat. `s_ready` stays high for every beat of that frame.
- R6: With `cfg_mode` = 0 or 3 (both), fields of both parities are doubled as in R3.
- R7: `cfg_en`, `cfg_mode` and `s_ftype` are sampled only on the accepted start-of-frame beat. Changing them later in the frame has no effect on that frame.
- R8: `s_ready` is low while a stored line is being replayed. An input beat is taken only when every earlier output beat has been accepted or is being accepted in that cycle.
- R9: While `m_valid` is high and `m_ready` is low, `m_valid` and all output fields hold steady.
- R10: `stat_pass`, `stat_double` and `stat_drop` start at 0 after reset. Each counts accepted end-of-frame beats of frames that were passed, doubled or dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Deinterlacing enable, read at start of frame |
| cfg_mode | input | 2 | Field selection: 0/3 both, 1 field 0 only, 2 field 1 only |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat ready |
| s_data | input | PIX*PLANES*BPS | Input pixel word |
| s_sof | input | 1 | First beat of a frame or field |
| s_eol | input | 1 | Last beat of a line |
| s_eof | input | 1 | Last beat of a frame or field |
| s_ftype | input | 2 | Frame type on the start beat: 0/3 progressive, 1 field 0, 2 field 1 |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Output beat ready |
| m_data | output | PIX*PLANES*BPS | Output pixel word |
| m_sof | output | 1 | First beat of an output frame |
| m_eol | output | 1 | Last beat of an output line |
| m_eof | output | 1 | Last beat of an output frame |
| stat_pass | output | STAT_W | Frames forwarded unchanged |
| stat_double | output | STAT_W | Fields line-doubled |
| stat_drop | output | STAT_W | Fields dropped |

## Verification
The bench sweeps every mix of enable, all four mode codes and all four frame-type codes. Each mix is run at line widths of one word, a few words, and exactly the store depth, with one to three lines per frame. This separates pass, drop and double behaviour for each parity, and it shows whether the last store word and the single-word line are handled right. After the start beat of each frame, the bench flips the enable, mode and type inputs, so any sampling at the wrong time shows up as a wrong frame shape. A pseudo-random output stall keeps the replay and the stall back-pressure overlapping. The bench checks that every input beat it sends to a kept frame goes in only when no earlier output is still owed.

// File: rtl/bob_pkg.sv
package bob_pkg;

  typedef enum logic [1:0] {
    ACT_PASS   = 2'd0,
    ACT_DOUBLE = 2'd1,
    ACT_DROP   = 2'd2
  } act_e;

  localparam logic [1:0] FT_F0   = 2'd1;
  localparam logic [1:0] FT_F1   = 2'd2;
  localparam logic [1:0] MODE_F0 = 2'd1;
  localparam logic [1:0] MODE_F1 = 2'd2;

  function automatic act_e pick_action(input logic en, input logic [1:0] mode,
                                       input logic [1:0] ftype);
    act_e a;
    if (!en || (ftype != FT_F0 && ftype != FT_F1))
      a = ACT_PASS;
    else if ((mode == MODE_F0 && ftype == FT_F1) || (mode == MODE_F1 && ftype == FT_F0))
      a = ACT_DROP;
    else
      a = ACT_DOUBLE;
    return a;
  endfunction

endpackage

// File: rtl/bob_act_sel.sv
module bob_act_sel
  import bob_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_en,
  input  logic [1:0] cfg_mode,
  input  logic [1:0] s_ftype,
  input  logic       s_sof,
  input  logic       take,
  output act_e       cur_act
);

  act_e act_q;
  act_e act_new;

  always_comb begin
    act_new = pick_action(cfg_en, cfg_mode, s_ftype);
    cur_act = s_sof ? act_new : act_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      act_q <= ACT_PASS;
    else if (take && s_sof)
      act_q <= act_new;
  end

endmodule

// File: rtl/bob_line_store.sv
module bob_line_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_first,
  input  logic          wr_last,
  input  logic          wr_eof,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_adv,
  output logic          replaying,
  output logic [DW-1:0] rd_data,
  output logic          rd_last,
  output logic          rd_eof
);

  localparam int AW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] FULL = AW'(DEPTH);
  localparam logic [AW-1:0] ONE  = AW'(1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] wr_addr;
  logic          wr_fits;
  logic [AW-1:0] rd_ptr;
  logic [AW-1:0] rd_len;

  assign wr_addr = wr_first ? '0 : wr_ptr;
  assign wr_fits = (wr_addr < FULL);
  assign rd_data = mem[rd_ptr[IW-1:0]];
  assign rd_last = (rd_ptr == rd_len - ONE);

  always_ff @(posedge clk) begin
    if (wr_en && wr_fits)
      mem[wr_addr[IW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      rd_len    <= ONE;
      replaying <= 1'b0;
      rd_eof    <= 1'b0;
    end else begin
      if (wr_en) begin
        if (wr_last) begin
          replaying <= 1'b1;
          rd_len    <= wr_fits ? wr_addr + ONE : FULL;
          rd_ptr    <= '0;
          wr_ptr    <= '0;
          rd_eof    <= wr_eof;
        end else begin
          wr_ptr <= wr_fits ? wr_addr + ONE : wr_addr;
        end
      end
      if (rd_adv) begin
        if (rd_last)
          replaying <= 1'b0;
        else
          rd_ptr <= rd_ptr + ONE;
      end
    end
  end

endmodule

// File: rtl/bob_out_stage.sv
module bob_out_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] in_data,
  input  logic          in_sof,
  input  logic          in_eol,
  input  logic          in_eof,
  output logic          can_load,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data,
  output logic          m_sof,
  output logic          m_eol,
  output logic          m_eof
);

  assign can_load = !m_valid || m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_sof   <= 1'b0;
      m_eol   <= 1'b0;
      m_eof   <= 1'b0;
    end else if (load) begin
      m_valid <= 1'b1;
      m_data  <= in_data;
      m_sof   <= in_sof;
      m_eol   <= in_eol;
      m_eof   <= in_eof;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/bob_stats.sv
module bob_stats
  import bob_pkg::*;
#(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev,
  input  act_e          ev_act,
  output logic [SW-1:0] stat_pass,
  output logic [SW-1:0] stat_double,
  output logic [SW-1:0] stat_drop
);

  localparam int NCNT = 3;
  logic [SW-1:0] cnt [NCNT];

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n)
        cnt[i] <= '0;
      else if (ev && (ev_act == act_e'(i)))
        cnt[i] <= cnt[i] + SW'(1);
    end
  end

  assign stat_pass   = cnt[ACT_PASS];
  assign stat_double = cnt[ACT_DOUBLE];
  assign stat_drop   = cnt[ACT_DROP];

endmodule

// File: rtl/bob_deint.sv
module bob_deint
  import bob_pkg::*;
#(
  parameter int PIX         = 2,
  parameter int PLANES      = 3,
  parameter int BPS         = 10,
  parameter int MAX_FIELD_W = 1024,
  parameter int STAT_W      = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_en,
  input  logic [1:0]                   cfg_mode,
  input  logic                         s_valid,
  output logic                         s_ready,
  input  logic [PIX*PLANES*BPS-1:0]    s_data,
  input  logic                         s_sof,
  input  logic                         s_eol,
  input  logic                         s_eof,
  input  logic [1:0]                   s_ftype,
  output logic                         m_valid,
  input  logic                         m_ready,
  output logic [PIX*PLANES*BPS-1:0]    m_data,
  output logic                         m_sof,
  output logic                         m_eol,
  output logic                         m_eof,
  output logic [STAT_W-1:0]            stat_pass,
  output logic [STAT_W-1:0]            stat_double,
  output logic [STAT_W-1:0]            stat_drop
);

  localparam int DW    = PIX * PLANES * BPS;
  localparam int DEPTH = (MAX_FIELD_W + PIX - 1) / PIX;

  act_e          cur_act;
  logic          replaying;
  logic          can_load;
  logic          in_fire;
  logic          live_load;
  logic          rep_load;
  logic [DW-1:0] rd_data;
  logic          rd_last;
  logic          rd_eof;
  logic [DW-1:0] o_data;
  logic          o_sof;
  logic          o_eol;
  logic          o_eof;

  assign s_ready   = !replaying && ((cur_act == ACT_DROP) || can_load);
  assign in_fire   = s_valid && s_ready;
  assign live_load = in_fire && (cur_act != ACT_DROP);
  assign rep_load  = replaying && can_load;

  always_comb begin
    if (replaying) begin
      o_data = rd_data;
      o_sof  = 1'b0;
      o_eol  = rd_last;
      o_eof  = rd_last && rd_eof;
    end else begin
      o_data = s_data;
      o_sof  = s_sof;
      o_eol  = s_eol;
      o_eof  = s_eof && (cur_act == ACT_PASS);
    end
  end

  bob_act_sel u_act (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_en   (cfg_en),
    .cfg_mode (cfg_mode),
    .s_ftype  (s_ftype),
    .s_sof    (s_sof),
    .take     (in_fire),
    .cur_act  (cur_act)
  );

  bob_line_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (in_fire && (cur_act == ACT_DOUBLE)),
    .wr_first  (s_sof),
    .wr_last   (s_eol),
    .wr_eof    (s_eof),
    .wr_data   (s_data),
    .rd_adv    (rep_load),
    .replaying (replaying),
    .rd_data   (rd_data),
    .rd_last   (rd_last),
    .rd_eof    (rd_eof)
  );

  bob_out_stage #(.DW(DW)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (live_load || rep_load),
    .in_data  (o_data),
    .in_sof   (o_sof),
    .in_eol   (o_eol),
    .in_eof   (o_eof),
    .can_load (can_load),
    .m_valid  (m_valid),
    .m_ready  (m_ready),
    .m_data   (m_data),
    .m_sof    (m_sof),
    .m_eol    (m_eol),
    .m_eof    (m_eof)
  );

  bob_stats #(.SW(STAT_W)) u_stats (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev          (in_fire && s_eof),
    .ev_act      (cur_act),
    .stat_pass   (stat_pass),
    .stat_double (stat_double),
    .stat_drop   (stat_drop)
  );

endmodule

// File: rtl/bob_deint_chk.sv
module bob_deint_chk
  import bob_pkg::*;
#(
  parameter int DW = 8,
  parameter int SW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_valid,
  input logic          s_ready,
  input logic [DW-1:0] s_data,
  input logic          s_eol,
  input logic          s_eof,
  input logic          m_valid,
  input logic          m_ready,
  input logic [DW-1:0] m_data,
  input logic          m_sof,
  input logic          m_eol,
  input logic          m_eof,
  input logic [SW-1:0] stat_pass,
  input logic [SW-1:0] stat_double,
  input logic [SW-1:0] stat_drop,
  input logic          replaying,
  input act_e          cur_act
);

  AST_PASS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready && cur_act == ACT_PASS |=>
      m_valid && m_data == $past(s_data) && m_eol == $past(s_eol) && m_eof == $past(s_eof)); // R1

  AST_DOUBLE_REPLAYS: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready && cur_act == ACT_DOUBLE && s_eol |=> replaying); // R3

  AST_DROP_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !replaying && cur_act == ACT_DROP |-> s_ready); // R4

  AST_REPLAY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    replaying |-> !s_ready); // R8

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_sof)
      && $stable(m_eol) && $stable(m_eof)); // R9

  AST_STAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stat_pass - $past(stat_pass)) + (stat_double - $past(stat_double))
             + (stat_drop - $past(stat_drop)) <= SW'(1)); // R10

endmodule

bind bob_deint bob_deint_chk #(.DW(DW), .SW(STAT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .s_valid     (s_valid),
  .s_ready     (s_ready),
  .s_data      (s_data),
  .s_eol       (s_eol),
  .s_eof       (s_eof),
  .m_valid     (m_valid),
  .m_ready     (m_ready),
  .m_data      (m_data),
  .m_sof       (m_sof),
  .m_eol       (m_eol),
  .m_eof       (m_eof),
  .stat_pass   (stat_pass),
  .stat_double (stat_double),
  .stat_drop   (stat_drop),
  .replaying   (replaying),
  .cur_act     (cur_act)
);

// File: tb/bob_deint_bench.sv
`timescale 1ns/1ps
module bob_deint_bench;

  localparam int PIX = 1, PLANES = 1, BPS = 8, MAXW = 16, SW = 16;
  localparam int DW = PIX * PLANES * BPS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_en = 1'b0;
  logic [1:0]    cfg_mode = 2'd0;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [DW-1:0] s_data = '0;
  logic          s_sof = 1'b0, s_eol = 1'b0, s_eof = 1'b0;
  logic [1:0]    s_ftype = 2'd0;
  logic          m_valid;
  logic          m_ready = 1'b0;
  logic [DW-1:0] m_data;
  logic          m_sof, m_eol, m_eof;
  logic [SW-1:0] stat_pass, stat_double, stat_drop;

  always #2.5 clk = ~clk;

  bob_deint #(.PIX(PIX), .PLANES(PLANES), .BPS(BPS), .MAX_FIELD_W(MAXW), .STAT_W(SW)) u_bob_deint (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_mode(cfg_mode),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_sof(s_sof),
    .s_eol(s_eol), .s_eof(s_eof), .s_ftype(s_ftype),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_sof(m_sof),
    .m_eol(m_eol), .m_eof(m_eof),
    .stat_pass(stat_pass), .stat_double(stat_double), .stat_drop(stat_drop)
  );

  int vectors = 0;
  int fails = 0;
  int n_pass = 0, n_double = 0, n_drop = 0;
  logic [10:0] expq[$];
  string tagq[$];
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  // output sink stall pattern, changed just after each rising edge
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    m_ready = lfsr[0] | lfsr[3];
  end

  // output scoreboard
  always @(negedge clk) begin
    if (rst_n && m_valid && m_ready) begin
      vectors++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL R4/R5 got beat %h expected no output", {m_sof, m_eol, m_eof, m_data});
      end else begin
        logic [10:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        if ({m_sof, m_eol, m_eof, m_data} !== e) begin
          fails++;
          $display("FAIL %s got %h expected %h", t, {m_sof, m_eol, m_eof, m_data}, e);
        end
      end
    end
  end

  function automatic logic [7:0] pix(input int f, input int ln, input int x);
    return 8'(f * 37 + ln * 11 + x * 3 + 1);
  endfunction

  task automatic send_frame(input bit en, input logic [1:0] mode, input logic [1:0] ft,
                            input int w, input int h, input int fidx);
    int act;  // 0 pass, 1 double, 2 drop
    string tag;
    if (!en || ft == 2'd0 || ft == 2'd3) act = 0;
    else if ((mode == 2'd1 && ft == 2'd2) || (mode == 2'd2 && ft == 2'd1)) act = 2;
    else act = 1;
    if (act == 0) tag = en ? "R1" : "R2";
    else if (act == 2) tag = (mode == 2'd1) ? "R4" : "R5";
    else tag = (mode == 2'd1 || mode == 2'd2) ? "R3" : "R6";
    for (int ln = 0; ln < h; ln++) begin
      for (int x = 0; x < w; x++) begin
        int waited;
        bit sof, eol, eof;
        sof = (ln == 0 && x == 0);
        eol = (x == w - 1);
        eof = eol && (ln == h - 1);
        if (sof) begin
          cfg_en = en; cfg_mode = mode; s_ftype = ft;
        end else begin
          // R7: scramble sampled inputs after the start beat
          cfg_en = ~en; cfg_mode = ~mode; s_ftype = ~ft;
        end
        s_valid = 1'b1; s_data = pix(fidx, ln, x);
        s_sof = sof; s_eol = eol; s_eof = eof;
        #1;
        waited = 0;
        while (!s_ready) begin
          @(negedge clk); #1; waited++;
          if (waited > 1000) break;
        end
        if (act == 2)
          chk(waited == 0, tag, waited, 0);
        else
          chk(expq.size() == 0, "R8", expq.size(), 0);
        if (act != 2) begin
          expq.push_back({sof, eol, eof && act == 0, pix(fidx, ln, x)});
          tagq.push_back(act == 0 ? tag : (eof ? "R7" : tag));
        end
        if (act == 1 && eol) begin
          for (int xx = 0; xx < w; xx++) begin
            expq.push_back({1'b0, xx == w - 1, (xx == w - 1) && (ln == h - 1), pix(fidx, ln, xx)});
            tagq.push_back(tag);
          end
        end
        @(negedge clk);
      end
    end
    s_valid = 1'b0; s_sof = 1'b0; s_eol = 1'b0; s_eof = 1'b0;
    if (act == 0) n_pass++;
    else if (act == 1) n_double++;
    else n_drop++;
    begin
      int g;
      g = 0;
      while (expq.size() != 0 && g < 1000) begin @(negedge clk); g++; end
      chk(expq.size() == 0, "R3", expq.size(), 0);
    end
    @(negedge clk);
    chk(stat_pass == SW'(n_pass), "R10", stat_pass, n_pass);
    chk(stat_double == SW'(n_double), "R10", stat_double, n_double);
    chk(stat_drop == SW'(n_drop), "R10", stat_drop, n_drop);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R8 got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int fidx;
    int widths[3];
    widths[0] = 1; widths[1] = 3; widths[2] = MAXW;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(m_valid == 1'b0, "R9", m_valid, 0);
    chk(s_ready == 1'b1, "R8", s_ready, 1);
    chk(stat_pass == 0 && stat_double == 0 && stat_drop == 0, "R10",
        stat_pass + stat_double + stat_drop, 0);
    @(negedge clk);
    fidx = 0;
    for (int en = 0; en < 2; en++)
      for (int mode = 0; mode < 4; mode++)
        for (int ft = 0; ft < 4; ft++)
          for (int wi = 0; wi < 3; wi++) begin
            send_frame(en[0], 2'(mode), 2'(ft), widths[wi], 1 + (fidx % 3), fidx);
            fidx++;
          end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule